// File: doc/BRIEF.md
# Enclave Lifecycle Sequencer

This block tracks the life of up to four isolated enclaves. A command port with valid/ready handshaking carries one command per cycle. Each command names a slot and asks to create the enclave, load a page into it, seal it, start executing it, or leave it. For every slot the block keeps a lifecycle state and a measurement register. Each page that is loaded is folded into the measurement by a keyed mixing function. Sealing the enclave freezes that value.

The block also tracks which enclave, if any, is executing. Every accepted command gets exactly one response in the next cycle. The response carries a result code and the measurement of the addressed slot. The protected-mode flag and the executing slot are registered outputs. Commands must follow a strict order. A command that breaks the order is answered with an error code and changes nothing.

Top module: `enclave_lifecycle_ctrl`

## Requirements
- R1: After reset all slots are free, `prot_mode` is 0, `rsp_valid` is 0 and `cmd_ready` is 0 while `rst` is high.
- R2: CREATE (op 1) is accepted only on a free slot. It moves the slot to building and sets the measurement to the seed 32'h6A09E667. On any other slot it returns code 2.
- R3: ADD (op 2) is accepted only on a building slot. In one cycle it sets m = rotl(m ^ digest, 5) + (addr zero-extended ^ (type << 30)) + 32'h9E3779B9, using 32-bit arithmetic. Otherwise it returns code 2.
- R4: INIT (op 3) is accepted only on a building slot and seals it. From then on the measurement never changes, and ADD or INIT on that slot returns code 2.
- R5: ENTER (op 4) on a slot that is not sealed returns code 2. On a sealed slot while an enclave is executing it returns code 3. Otherwise it sets `prot_mode` to 1 and `active_slot` to the slot.
- R6: EXIT (op 5) is accepted only for the executing slot, and it clears `prot_mode`. Any other EXIT returns code 4. A sealed enclave can be entered again any number of times, and its measurement stays the same.
- R7: Op codes 0, 6 and 7 return code 1.
- R8: A rejected command leaves every slot state, every measurement, `prot_mode` and `active_slot` unchanged. The response still reports the addressed slot's measurement.
- R9: `cmd_ready` is 1 from the first clock after reset is released. Each handshake makes `rsp_valid` 1 in the next cycle, with code 0 on acceptance. A cycle with no handshake makes `rsp_valid` 0 in the next cycle.
- R10: Slots are independent: a command on one slot never changes the state or the measurement of another slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Block can take a command |
| cmd_op | input | 3 | Operation code |
| cmd_slot | input | 2 | Target enclave slot |
| cmd_addr | input | 20 | Page address for ADD |
| cmd_type | input | 2 | Page type for ADD |
| cmd_digest | input | 32 | Page content digest for ADD |
| rsp_valid | output | 1 | Response present |
| rsp_code | output | 3 | 0 ok, 1 bad op, 2 wrong state, 3 busy, 4 not executing |
| rsp_meas | output | 32 | Measurement of the addressed slot after the command |
| prot_mode | output | 1 | An enclave is executing |
| active_slot | output | 2 | Executing slot, valid while `prot_mode` is 1 |

## Verification
Every result is registered once. The response fields, `prot_mode` and `active_slot` all change at the first rising edge after the handshake, and the slot state and measurement update at that same edge. The bench drives each command on a falling edge and compares all outputs with its reference model on the next falling edge, so each sample lands one full edge after its stimulus. Idle cycles are compared the same way, which checks that `rsp_valid` drops one cycle after the handshake stops.

// File: rtl/enclave_pkg.sv
package enclave_pkg;

  typedef enum logic [2:0] {
    OP_NOP    = 3'd0,
    OP_CREATE = 3'd1,
    OP_ADD    = 3'd2,
    OP_INIT   = 3'd3,
    OP_ENTER  = 3'd4,
    OP_EXIT   = 3'd5
  } op_e;

  typedef enum logic [2:0] {
    RC_OK          = 3'd0,
    RC_BAD_OP      = 3'd1,
    RC_BAD_STATE   = 3'd2,
    RC_BUSY        = 3'd3,
    RC_NOT_RUNNING = 3'd4
  } code_e;

  typedef enum logic [1:0] {
    SL_FREE   = 2'd0,
    SL_BUILD  = 2'd1,
    SL_SEALED = 2'd2
  } slot_state_e;

endpackage

// File: rtl/enclave_mix.sv
module enclave_mix #(
  parameter int          MEAS_W = 32,
  parameter int          ADDR_W = 20,
  parameter int          TYPE_W = 2,
  parameter int          ROT    = 5,
  parameter logic [31:0] KEY    = 32'h9E3779B9
) (
  input  logic [MEAS_W-1:0] meas_in,
  input  logic [ADDR_W-1:0] addr,
  input  logic [TYPE_W-1:0] typ,
  input  logic [MEAS_W-1:0] digest,
  output logic [MEAS_W-1:0] meas_out
);
  localparam int TYPE_SH = MEAS_W - TYPE_W;

  logic [MEAS_W-1:0] folded, rotated, word;

  always_comb begin
    folded   = meas_in ^ digest;
    rotated  = (folded << ROT) | (folded >> (MEAS_W - ROT));
    word     = MEAS_W'(addr) ^ (MEAS_W'(typ) << TYPE_SH);
    meas_out = rotated + word + MEAS_W'(KEY);
  end
endmodule

// File: rtl/enclave_slot_table.sv
module enclave_slot_table
  import enclave_pkg::*;
#(
  parameter int SLOTS  = 4,
  parameter int MEAS_W = 32,
  localparam int SLOT_W = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [SLOT_W-1:0] slot,
  input  logic              st_we,
  input  slot_state_e       st_wd,
  input  logic              meas_we,
  input  logic [MEAS_W-1:0] meas_wd,
  output slot_state_e       st_rd,
  output logic [MEAS_W-1:0] meas_rd
);
  slot_state_e       st_q [SLOTS];
  logic [MEAS_W-1:0] mem  [SLOTS];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < SLOTS; i++) st_q[i] <= SL_FREE;
    end else if (st_we) begin
      st_q[slot] <= st_wd;
    end
  end

  // measurement store: single write port, no reset, RAM-inferable
  always_ff @(posedge clk) begin
    if (meas_we) mem[slot] <= meas_wd;
  end

  assign st_rd   = st_q[slot];
  assign meas_rd = mem[slot];

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot_chk
    // R4
    meas_frozen_chk: assert property (@(posedge clk) disable iff (rst)
      (st_q[g] == SL_SEALED && $past(st_q[g]) == SL_SEALED) |-> mem[g] == $past(mem[g]));
    // R4
    sealed_sticky_chk: assert property (@(posedge clk) disable iff (rst)
      ($past(st_q[g]) == SL_SEALED) |-> st_q[g] == SL_SEALED);
  end
endmodule

// File: rtl/enclave_cmd_check.sv
module enclave_cmd_check
  import enclave_pkg::*;
#(
  parameter int SLOTS = 4,
  localparam int SLOT_W = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input  logic              go,
  input  logic [2:0]        op,
  input  logic [SLOT_W-1:0] slot,
  input  slot_state_e       state,
  input  logic              running,
  input  logic [SLOT_W-1:0] run_slot,
  output code_e             code,
  output logic              st_we,
  output slot_state_e       st_wd,
  output logic              meas_we,
  output logic              seed_sel,
  output logic              run_set,
  output logic              run_clr
);
  logic ok;

  always_comb begin
    code     = RC_OK;
    st_wd    = state;
    st_we    = 1'b0;
    meas_we  = 1'b0;
    seed_sel = 1'b0;
    run_set  = 1'b0;
    run_clr  = 1'b0;
    case (op)
      OP_CREATE: begin
        if (state != SL_FREE) code = RC_BAD_STATE;
        st_we = 1'b1; st_wd = SL_BUILD; meas_we = 1'b1; seed_sel = 1'b1;
      end
      OP_ADD: begin
        if (state != SL_BUILD) code = RC_BAD_STATE;
        meas_we = 1'b1;
      end
      OP_INIT: begin
        if (state != SL_BUILD) code = RC_BAD_STATE;
        st_we = 1'b1; st_wd = SL_SEALED;
      end
      OP_ENTER: begin
        if (state != SL_SEALED) code = RC_BAD_STATE;
        else if (running)       code = RC_BUSY;
        run_set = 1'b1;
      end
      OP_EXIT: begin
        if (!running || run_slot != slot) code = RC_NOT_RUNNING;
        run_clr = 1'b1;
      end
      default: code = RC_BAD_OP;
    endcase
    ok       = go && (code == RC_OK);
    st_we    = st_we   && ok;
    meas_we  = meas_we && ok;
    run_set  = run_set && ok;
    run_clr  = run_clr && ok;
  end
endmodule

// File: rtl/enclave_lifecycle_ctrl.sv
module enclave_lifecycle_ctrl
  import enclave_pkg::*;
#(
  parameter int          SLOTS  = 4,
  parameter int          ADDR_W = 20,
  parameter int          TYPE_W = 2,
  parameter int          MEAS_W = 32,
  parameter logic [31:0] SEED   = 32'h6A09E667,
  parameter logic [31:0] KEY    = 32'h9E3779B9,
  localparam int SLOT_W = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [2:0]        cmd_op,
  input  logic [SLOT_W-1:0] cmd_slot,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [TYPE_W-1:0] cmd_type,
  input  logic [MEAS_W-1:0] cmd_digest,
  output logic              rsp_valid,
  output logic [2:0]        rsp_code,
  output logic [MEAS_W-1:0] rsp_meas,
  output logic              prot_mode,
  output logic [SLOT_W-1:0] active_slot
);
  logic              accept;
  slot_state_e       cur_state, st_wd;
  logic [MEAS_W-1:0] cur_meas, mixed, meas_wd;
  code_e             code;
  logic              st_we, meas_we, seed_sel, run_set, run_clr;

  assign accept = cmd_valid && cmd_ready;

  enclave_slot_table #(.SLOTS(SLOTS), .MEAS_W(MEAS_W)) u_table (
    .clk(clk), .rst(rst), .slot(cmd_slot),
    .st_we(st_we), .st_wd(st_wd), .meas_we(meas_we), .meas_wd(meas_wd),
    .st_rd(cur_state), .meas_rd(cur_meas)
  );

  enclave_cmd_check #(.SLOTS(SLOTS)) u_check (
    .go(accept), .op(cmd_op), .slot(cmd_slot), .state(cur_state),
    .running(prot_mode), .run_slot(active_slot),
    .code(code), .st_we(st_we), .st_wd(st_wd), .meas_we(meas_we),
    .seed_sel(seed_sel), .run_set(run_set), .run_clr(run_clr)
  );

  enclave_mix #(.MEAS_W(MEAS_W), .ADDR_W(ADDR_W), .TYPE_W(TYPE_W), .KEY(KEY)) u_mix (
    .meas_in(cur_meas), .addr(cmd_addr), .typ(cmd_type), .digest(cmd_digest),
    .meas_out(mixed)
  );

  assign meas_wd = seed_sel ? MEAS_W'(SEED) : mixed;

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_ready   <= 1'b0;
      rsp_valid   <= 1'b0;
      rsp_code    <= 3'd0;
      rsp_meas    <= '0;
      prot_mode   <= 1'b0;
      active_slot <= '0;
    end else begin
      cmd_ready <= 1'b1;
      rsp_valid <= accept;
      if (accept) begin
        rsp_code <= code;
        rsp_meas <= meas_we ? meas_wd : cur_meas;
      end
      if (run_set) begin
        prot_mode   <= 1'b1;
        active_slot <= cmd_slot;
      end else if (run_clr) begin
        prot_mode <= 1'b0;
      end
    end
  end

  // R9
  rsp_follow_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_ready) |=> rsp_valid);
  // R9
  rsp_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !(cmd_valid && cmd_ready) |=> !rsp_valid);
  // R8
  reject_keeps_mode_chk: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_code != 3'd0) |-> (prot_mode == $past(prot_mode) && active_slot == $past(active_slot)));
  // R5
  enter_ok_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(prot_mode) |-> (rsp_valid && rsp_code == 3'd0));
  // R6
  exit_ok_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(prot_mode) |-> (rsp_valid && rsp_code == 3'd0));
endmodule

// File: tb/enclave_lifecycle_ctrl_test.sv
module enclave_lifecycle_ctrl_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [2:0]  cmd_op = 3'd0;
  logic [1:0]  cmd_slot = 2'd0;
  logic [19:0] cmd_addr = '0;
  logic [1:0]  cmd_type = '0;
  logic [31:0] cmd_digest = '0;
  logic        rsp_valid;
  logic [2:0]  rsp_code;
  logic [31:0] rsp_meas;
  logic        prot_mode;
  logic [1:0]  active_slot;

  always #4 clk = ~clk;

  enclave_lifecycle_ctrl uut (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_slot(cmd_slot), .cmd_addr(cmd_addr), .cmd_type(cmd_type),
    .cmd_digest(cmd_digest), .rsp_valid(rsp_valid), .rsp_code(rsp_code),
    .rsp_meas(rsp_meas), .prot_mode(prot_mode), .active_slot(active_slot)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // reference model
  int          m_st [4];   // 0 free, 1 building, 2 sealed
  logic [31:0] m_meas [4];
  bit          m_run = 0;
  int          m_rslot = 0;

  function automatic logic [31:0] mix_ref(logic [31:0] m, logic [19:0] a, logic [1:0] t, logic [31:0] d);
    logic [31:0] x;
    x = m ^ d;
    x = {x[26:0], x[31:27]};
    return x + ({t, 30'd0} ^ {12'd0, a}) + 32'h9E3779B9;
  endfunction

  task automatic check(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  task automatic compare_mode(string req);
    check(prot_mode == m_run, req, "prot_mode", 32'(prot_mode), 32'(m_run));
    if (m_run)
      check(active_slot == 2'(m_rslot), req, "active_slot", 32'(active_slot), 32'(m_rslot));
  endtask

  // drive one command; expected values come from the model; exp_code < 0 means no directed value
  task automatic issue(int op, int slot, logic [19:0] a, logic [1:0] t, logic [31:0] d, int exp_code, string req);
    int code;
    cmd_valid = 1; cmd_op = 3'(op); cmd_slot = 2'(slot);
    cmd_addr = a; cmd_type = t; cmd_digest = d;
    code = 0;
    case (op)
      1: if (m_st[slot] != 0) code = 2; else begin m_st[slot] = 1; m_meas[slot] = 32'h6A09E667; end
      2: if (m_st[slot] != 1) code = 2; else m_meas[slot] = mix_ref(m_meas[slot], a, t, d);
      3: if (m_st[slot] != 1) code = 2; else m_st[slot] = 2;
      4: if (m_st[slot] != 2) code = 2; else if (m_run) code = 3; else begin m_run = 1; m_rslot = slot; end
      5: if (!m_run || m_rslot != slot) code = 4; else m_run = 0;
      default: code = 1;
    endcase
    @(negedge clk);
    if (exp_code >= 0)
      check(code == exp_code, req, "model code", 32'(code), 32'(exp_code));
    check(rsp_valid == 1'b1, "R9", "rsp_valid", 32'(rsp_valid), 32'd1);
    check(rsp_code == 3'(code), req, "rsp_code", 32'(rsp_code), 32'(code));
    if (m_st[slot] != 0)
      check(rsp_meas == m_meas[slot], req, "rsp_meas", rsp_meas, m_meas[slot]);
    compare_mode(req);
    cmd_valid = 0;
  endtask

  task automatic idle(int n);
    cmd_valid = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      check(rsp_valid == 1'b0, "R9", "rsp_valid idle", 32'(rsp_valid), 32'd0);
      compare_mode("R8");
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
  end

  initial begin
    logic [15:0] lf;
    for (int i = 0; i < 4; i++) begin m_st[i] = 0; m_meas[i] = '0; end
    repeat (3) @(negedge clk);
    check(rsp_valid == 0, "R1", "rsp_valid in reset", 32'(rsp_valid), 0);
    check(cmd_ready == 0, "R1", "cmd_ready in reset", 32'(cmd_ready), 0);
    check(prot_mode == 0, "R1", "prot_mode in reset", 32'(prot_mode), 0);
    rst = 0;
    @(negedge clk);
    check(cmd_ready == 1, "R9", "cmd_ready", 32'(cmd_ready), 1);
    idle(1);

    // R1: fresh slots reject use
    issue(4, 0, 0, 0, 0, 2, "R1");
    issue(2, 0, 20'h1, 0, 32'h5, 2, "R1");
    issue(5, 0, 0, 0, 0, 4, "R1");
    // R7: bad op codes
    issue(0, 1, 0, 0, 0, 1, "R7");
    issue(6, 2, 0, 0, 0, 1, "R7");
    issue(7, 3, 0, 0, 0, 1, "R7");
    // R2
    issue(1, 0, 0, 0, 0, 0, "R2");
    check(rsp_meas == 32'h6A09E667, "R2", "seed", rsp_meas, 32'h6A09E667);
    issue(1, 0, 0, 0, 0, 2, "R2");
    // R3
    issue(2, 0, 20'h00010, 2'd0, 32'hDEADBEEF, 0, "R3");
    issue(2, 0, 20'hFFFFF, 2'd3, 32'h00000000, 0, "R3");
    idle(2);
    issue(2, 0, 20'h12345, 2'd1, 32'hFFFFFFFF, 0, "R3");
    // R4
    issue(3, 0, 0, 0, 0, 0, "R4");
    issue(2, 0, 20'h00001, 2'd1, 32'h1234, 2, "R4");
    issue(3, 0, 0, 0, 0, 2, "R4");
    // R5
    issue(4, 0, 0, 0, 0, 0, "R5");
    issue(4, 0, 0, 0, 0, 3, "R5");
    // R10: build slot 1 while slot 0 executes
    issue(1, 1, 0, 0, 0, 0, "R10");
    issue(2, 1, 20'h00400, 2'd2, 32'hCAFEF00D, 0, "R10");
    issue(3, 1, 0, 0, 0, 0, "R10");
    issue(3, 0, 0, 0, 0, 2, "R10");
    issue(4, 1, 0, 0, 0, 3, "R5");
    issue(4, 2, 0, 0, 0, 2, "R5");
    // R6
    issue(5, 1, 0, 0, 0, 4, "R6");
    issue(5, 0, 0, 0, 0, 0, "R6");
    issue(5, 0, 0, 0, 0, 4, "R6");
    issue(4, 0, 0, 0, 0, 0, "R6");
    issue(5, 0, 0, 0, 0, 0, "R6");
    issue(4, 1, 0, 0, 0, 0, "R6");
    idle(3);
    issue(5, 1, 0, 0, 0, 0, "R6");
    // R8: reject on a building slot leaves its measurement
    issue(1, 2, 0, 0, 0, 0, "R8");
    issue(4, 2, 0, 0, 0, 2, "R8");
    issue(2, 2, 20'h00077, 2'd0, 32'h00000077, 0, "R8");

    // pseudo-random traffic against the model
    lf = 16'hACE1;
    for (int n = 0; n < 600; n++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      if (lf[15:13] == 3'd0) idle(1);
      else begin
        string tag;
        case (int'(lf[2:0]))
          1: tag = "R2"; 2: tag = "R3"; 3: tag = "R4"; 4: tag = "R5"; 5: tag = "R6";
          default: tag = "R7";
        endcase
        issue(int'(lf[2:0]), int'(lf[4:3]), {lf[11:0], lf[15:8]}, lf[6:5],
              {lf, lf ^ 16'h5A5A}, -1, tag);
      end
    end
    idle(2);
    summary();
  end
endmodule